// File: doc/BRIEF.md
# Iterative Triple DES Engine

This block encrypts or decrypts one 64-bit block with Triple DES. A single DES round is built once and reused for 48 consecutive clock cycles, one round per cycle. A round counter and a pass counter step through three chained DES passes. Together they pick which of the three 56-bit subkeys feeds the round and whether the round keys are walked forward or in reverse.

The initial permutation is applied once when the block is loaded and the final permutation once at the output. Between passes the halves are kept exactly as a standalone DES output followed by a fresh DES input would leave them, so the result equals three separate DES calls. A parity checker examines the 168-bit key as 21 bytes and flags any byte with an even number of ones when checking is enabled.

Top module: `tdes_engine`

## Requirements
- R1: With `decrypt_i` low at start, the result is DES-encrypt with K1, then DES-decrypt with K2, then DES-encrypt with K3.
- R2: With `decrypt_i` high at start, the result is DES-decrypt with K3, then DES-encrypt with K2, then DES-decrypt with K1. Decrypting a ciphertext produced under the same key returns the plaintext.
- R3: K1 is `key_i[167:112]`, K2 is `key_i[111:56]` and K3 is `key_i[55:0]`. Each 56-bit subkey is a 64-bit DES key with bit 0 of every byte removed and the remaining bits kept in order. When K1, K2 and K3 are equal, the result is single DES.
- R4: If `start_i` is sampled high at clock edge n while idle, `done_o` is high for exactly the one cycle that follows edge n+48. `data_o` carries the result in that cycle.
- R5: `start_i` has no effect while an operation is running. The running result, the operation's mode and the timing of `done_o` are all unchanged by it.
- R6: After `done_o`, `data_o` holds its value until the next accepted start, whatever `data_i` and `decrypt_i` do.
- R7: With `parity_en_i` high, `parity_err_o` is high, combinationally, exactly when some key byte `key_i[8j+7:8j]` (j = 0..20) holds an even number of ones.
- R8: With `parity_en_i` low, `parity_err_o` is low.
- R9: After reset, `done_o` is low and `data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when idle |
| decrypt_i | input | 1 | 1 = decrypt, 0 = encrypt; sampled at start |
| data_i | input | 64 | Input block, sampled at start |
| key_i | input | 168 | Three 56-bit subkeys K1, K2, K3; must be held during an operation |
| parity_en_i | input | 1 | Enables the key parity check |
| data_o | output | 64 | Result block |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| parity_err_o | output | 1 | Key parity failure |

## Verification
The hardest case to reach is a start strobe that arrives in the middle of a running operation, carrying a different block and the opposite mode. The bench raises such a strobe ten cycles into an encryption. It then checks that the known ciphertext still appears on the original 48-cycle schedule. Subkey placement is exercised with keys in which two of the three thirds are equal. The chain then collapses to a single DES under the remaining third, so a misplaced field or a wrong pass order yields a wrong known answer.

// File: rtl/tdes_pkg.sv
package tdes_pkg;
  localparam int BLK_W  = 64;
  localparam int HALF_W = BLK_W / 2;
  localparam int KEY_W  = 56;
  localparam int SUB_W  = 48;
  localparam int NKEYS  = 3;
  localparam int CKEY_W = KEY_W * NKEYS;
  localparam int ROUNDS = 16;
  localparam int RND_W  = $clog2(ROUNDS);
  localparam int PASS_W = $clog2(NKEYS);
  localparam int KBYTES = CKEY_W / 8;

  typedef logic [BLK_W-1:0]  blk_t;
  typedef logic [HALF_W-1:0] half_t;
  typedef logic [KEY_W-1:0]  key_t;
  typedef logic [SUB_W-1:0]  sub_t;

  localparam int IP_T [64] = '{58,50,42,34,26,18,10,2,60,52,44,36,28,20,12,4,
                               62,54,46,38,30,22,14,6,64,56,48,40,32,24,16,8,
                               57,49,41,33,25,17,9,1,59,51,43,35,27,19,11,3,
                               61,53,45,37,29,21,13,5,63,55,47,39,31,23,15,7};
  localparam int FP_T [64] = '{40,8,48,16,56,24,64,32,39,7,47,15,55,23,63,31,
                               38,6,46,14,54,22,62,30,37,5,45,13,53,21,61,29,
                               36,4,44,12,52,20,60,28,35,3,43,11,51,19,59,27,
                               34,2,42,10,50,18,58,26,33,1,41,9,49,17,57,25};
  localparam int E_T [48]  = '{32,1,2,3,4,5,4,5,6,7,8,9,8,9,10,11,12,13,12,13,14,15,16,17,
                               16,17,18,19,20,21,20,21,22,23,24,25,24,25,26,27,28,29,28,29,30,31,32,1};
  localparam int P_T [32]  = '{16,7,20,21,29,12,28,17,1,15,23,26,5,18,31,10,
                               2,8,24,14,32,27,3,9,19,13,30,6,22,11,4,25};
  localparam int PC1_T [56] = '{57,49,41,33,25,17,9,1,58,50,42,34,26,18,10,2,59,51,43,35,27,19,11,3,
                                60,52,44,36,63,55,47,39,31,23,15,7,62,54,46,38,30,22,14,6,
                                61,53,45,37,29,21,13,5,28,20,12,4};
  localparam int PC2_T [48] = '{14,17,11,24,1,5,3,28,15,6,21,10,23,19,12,4,26,8,16,7,27,20,13,2,
                                41,52,31,37,47,55,30,40,51,45,33,48,44,49,39,56,34,53,46,42,50,36,29,32};
  // cumulative left rotation of C/D after each round
  localparam int CUM_T [16] = '{1,2,4,6,8,10,12,14,15,17,19,21,23,25,27,28};

  localparam int S1_T [64] = '{14,4,13,1,2,15,11,8,3,10,6,12,5,9,0,7, 0,15,7,4,14,2,13,1,10,6,12,11,9,5,3,8,
                               4,1,14,8,13,6,2,11,15,12,9,7,3,10,5,0, 15,12,8,2,4,9,1,7,5,11,3,14,10,0,6,13};
  localparam int S2_T [64] = '{15,1,8,14,6,11,3,4,9,7,2,13,12,0,5,10, 3,13,4,7,15,2,8,14,12,0,1,10,6,9,11,5,
                               0,14,7,11,10,4,13,1,5,8,12,6,9,3,2,15, 13,8,10,1,3,15,4,2,11,6,7,12,0,5,14,9};
  localparam int S3_T [64] = '{10,0,9,14,6,3,15,5,1,13,12,7,11,4,2,8, 13,7,0,9,3,4,6,10,2,8,5,14,12,11,15,1,
                               13,6,4,9,8,15,3,0,11,1,2,12,5,10,14,7, 1,10,13,0,6,9,8,7,4,15,14,3,11,5,2,12};
  localparam int S4_T [64] = '{7,13,14,3,0,6,9,10,1,2,8,5,11,12,4,15, 13,8,11,5,6,15,0,3,4,7,2,12,1,10,14,9,
                               10,6,9,0,12,11,7,13,15,1,3,14,5,2,8,4, 3,15,0,6,10,1,13,8,9,4,5,11,12,7,2,14};
  localparam int S5_T [64] = '{2,12,4,1,7,10,11,6,8,5,3,15,13,0,14,9, 14,11,2,12,4,7,13,1,5,0,15,10,3,9,8,6,
                               4,2,1,11,10,13,7,8,15,9,12,5,6,3,0,14, 11,8,12,7,1,14,2,13,6,15,0,9,10,4,5,3};
  localparam int S6_T [64] = '{12,1,10,15,9,2,6,8,0,13,3,4,14,7,5,11, 10,15,4,2,7,12,9,5,6,1,13,14,0,11,3,8,
                               9,14,15,5,2,8,12,3,7,0,4,10,1,13,11,6, 4,3,2,12,9,5,15,10,11,14,1,7,6,0,8,13};
  localparam int S7_T [64] = '{4,11,2,14,15,0,8,13,3,12,9,7,5,10,6,1, 13,0,11,7,4,9,1,10,14,3,5,12,2,15,8,6,
                               1,4,11,13,12,3,7,14,10,15,6,8,0,5,9,2, 6,11,13,8,1,4,10,7,9,5,0,15,14,2,3,12};
  localparam int S8_T [64] = '{13,2,8,4,6,15,11,1,10,9,3,14,5,0,12,7, 1,15,13,8,10,3,7,4,12,5,6,11,0,14,9,2,
                               7,11,4,1,9,12,14,2,0,6,10,13,15,3,5,8, 2,1,14,7,4,10,8,13,15,12,9,0,3,5,6,11};

  // table entries number bits from 1 at the MSB
  function automatic blk_t ip_f(input blk_t x);
    for (int i = 0; i < 64; i++) ip_f[63-i] = x[64-IP_T[i]];
  endfunction

  function automatic blk_t fp_f(input blk_t x);
    for (int i = 0; i < 64; i++) fp_f[63-i] = x[64-FP_T[i]];
  endfunction

  function automatic sub_t e_f(input half_t x);
    for (int i = 0; i < 48; i++) e_f[47-i] = x[32-E_T[i]];
  endfunction

  function automatic half_t p_f(input half_t x);
    for (int i = 0; i < 32; i++) p_f[31-i] = x[32-P_T[i]];
  endfunction

  function automatic key_t pc1_f(input blk_t x);
    for (int i = 0; i < 56; i++) pc1_f[55-i] = x[64-PC1_T[i]];
  endfunction

  function automatic sub_t pc2_f(input key_t x);
    for (int i = 0; i < 48; i++) pc2_f[47-i] = x[56-PC2_T[i]];
  endfunction

  function automatic logic [3:0] sbox_f(input int n, input logic [5:0] b);
    int idx;
    int v;
    idx = {26'd0, b[5], b[0], b[4:1]};
    case (n)
      0: v = S1_T[idx];
      1: v = S2_T[idx];
      2: v = S3_T[idx];
      3: v = S4_T[idx];
      4: v = S5_T[idx];
      5: v = S6_T[idx];
      6: v = S7_T[idx];
      default: v = S8_T[idx];
    endcase
    sbox_f = v[3:0];
  endfunction
endpackage

// File: rtl/tdes_ctrl.sv
module tdes_ctrl
  import tdes_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              decrypt_i,
  output logic              load_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              dec_o,
  output logic [RND_W-1:0]  rnd_o,
  output logic [PASS_W-1:0] pass_o,
  output logic              last_o
);
  localparam logic [RND_W-1:0]  RND_LAST  = RND_W'(ROUNDS - 1);
  localparam logic [PASS_W-1:0] PASS_LAST = PASS_W'(NKEYS - 1);

  logic              busy_q, done_q, dec_q;
  logic [RND_W-1:0]  rnd_q;
  logic [PASS_W-1:0] pass_q;

  assign load_o = start_i & ~busy_q;
  assign last_o = (rnd_q == RND_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dec_q  <= 1'b0;
      rnd_q  <= '0;
      pass_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        busy_q <= 1'b1;
        dec_q  <= decrypt_i;
        rnd_q  <= '0;
        pass_q <= '0;
      end else if (busy_q) begin
        if (last_o) begin
          rnd_q <= '0;
          if (pass_q == PASS_LAST) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            pass_q <= '0;
          end else begin
            pass_q <= pass_q + 1'b1;
          end
        end else begin
          rnd_q <= rnd_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign dec_o  = dec_q;
  assign rnd_o  = rnd_q;
  assign pass_o = pass_q;

  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R4
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && last_o && pass_q == PASS_LAST) |=> (done_q && !busy_q));
  // R4
  pass_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (pass_q <= PASS_LAST));
  // R5
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> $stable(dec_q));
endmodule

// File: rtl/tdes_key_sched.sv
module tdes_key_sched
  import tdes_pkg::*;
(
  input  key_t             key_i,
  input  logic [RND_W-1:0] rnd_i,
  input  logic             rev_i,
  output sub_t             sub_o
);
  localparam int HK = KEY_W / 2;

  blk_t                k64;
  key_t                cd;
  logic [RND_W-1:0]    idx;
  logic [5:0]          amt;
  logic [2*HK-1:0]     c2, d2;

  always_comb begin
    // restore byte layout with zero parity bits so the standard PC-1 applies
    for (int b = 0; b < 8; b++) begin
      k64[8*b]      = 1'b0;
      k64[8*b+1 +: 7] = key_i[7*b +: 7];
    end
    cd  = pc1_f(k64);
    idx = rev_i ? ~rnd_i : rnd_i;
    amt = 6'(CUM_T[idx]);
    c2  = {cd[KEY_W-1:HK], cd[KEY_W-1:HK]} << amt;
    d2  = {cd[HK-1:0], cd[HK-1:0]} << amt;
    sub_o = pc2_f({c2[2*HK-1:HK], d2[2*HK-1:HK]});
  end
endmodule

// File: rtl/tdes_round.sv
module tdes_round
  import tdes_pkg::*;
(
  input  half_t l_i,
  input  half_t r_i,
  input  sub_t  k_i,
  input  logic  last_i,
  output half_t l_o,
  output half_t r_o
);
  sub_t  x;
  half_t s, mix;

  always_comb begin
    x = e_f(r_i) ^ k_i;
    for (int n = 0; n < 8; n++) s[31-4*n -: 4] = sbox_f(n, x[47-6*n -: 6]);
    mix = l_i ^ p_f(s);
    // final round of a pass keeps halves unswapped
    l_o = last_i ? mix : r_i;
    r_o = last_i ? r_i : mix;
  end
endmodule

// File: rtl/tdes_parity.sv
module tdes_parity
  import tdes_pkg::*;
(
  input  logic [CKEY_W-1:0] key_i,
  input  logic              en_i,
  output logic              err_o
);
  logic [KBYTES-1:0] bad;

  for (genvar j = 0; j < KBYTES; j++) begin : g_byte
    assign bad[j] = ~^key_i[8*j +: 8];
  end

  assign err_o = en_i & (|bad);
endmodule

// File: rtl/tdes_engine.sv
module tdes_engine
  import tdes_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          decrypt_i,
  input  logic [63:0]   data_i,
  input  logic [167:0]  key_i,
  input  logic          parity_en_i,
  output logic [63:0]   data_o,
  output logic          done_o,
  output logic          parity_err_o
);
  logic              load, busy, dec, last;
  logic [RND_W-1:0]  rnd;
  logic [PASS_W-1:0] pass;
  logic [PASS_W-1:0] ksel;
  logic              rev;
  key_t              key_cur;
  sub_t              sub;
  half_t             l_q, r_q, l_n, r_n;

  tdes_ctrl i_ctrl (
    .clk_i, .rst_ni, .start_i, .decrypt_i,
    .load_o(load), .busy_o(busy), .done_o, .dec_o(dec),
    .rnd_o(rnd), .pass_o(pass), .last_o(last)
  );

  // encrypt walks K1,K2,K3; decrypt walks K3,K2,K1; middle pass inverts
  assign ksel = dec ? PASS_W'(NKEYS - 1) - pass : pass;
  assign rev  = dec ^ (pass == PASS_W'(1));

  always_comb begin
    case (ksel)
      2'd0:    key_cur = key_i[CKEY_W-1 -: KEY_W];
      2'd1:    key_cur = key_i[CKEY_W-KEY_W-1 -: KEY_W];
      default: key_cur = key_i[KEY_W-1:0];
    endcase
  end

  tdes_key_sched i_ks (.key_i(key_cur), .rnd_i(rnd), .rev_i(rev), .sub_o(sub));

  tdes_round i_rnd (.l_i(l_q), .r_i(r_q), .k_i(sub), .last_i(last), .l_o(l_n), .r_o(r_n));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_q <= '0;
      r_q <= '0;
    end else if (load) begin
      {l_q, r_q} <= ip_f(data_i);
    end else if (busy) begin
      l_q <= l_n;
      r_q <= r_n;
    end
  end

  assign data_o = fp_f({l_q, r_q});

  tdes_parity i_par (.key_i, .en_i(parity_en_i), .err_o(parity_err_o));

  // R6
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start_i) |=> $stable(data_o));
  // R8
  parity_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !parity_en_i |-> !parity_err_o);
endmodule

// File: tb/test_tdes_engine.sv
module test_tdes_engine;
  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          decrypt_i = 1'b0;
  logic [63:0]   data_i = '0;
  logic [167:0]  key_i = '0;
  logic          parity_en_i = 1'b0;
  logic [63:0]   data_o;
  logic          done_o;
  logic          parity_err_o;

  int checks = 0;
  int errors = 0;

  always #2ns clk_i = ~clk_i;

  tdes_engine i_tdes_engine (.*);

  function automatic logic [55:0] k56(input logic [63:0] k);
    for (int b = 0; b < 8; b++) k56[7*b +: 7] = k[8*b+1 +: 7];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R4: result and done timing
  task automatic run_op(input logic dec, input logic [63:0] din, input logic [167:0] key,
                        output logic [63:0] dout, input string req);
    int n;
    n = 0;
    @(negedge clk_i);
    decrypt_i = dec; data_i = din; key_i = key; start_i = 1'b1;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      if (done_o) begin n = k; break; end
    end
    check("R4 done latency", 64'(n), 64'd49);
    dout = data_o;
    @(negedge clk_i);
    check("R4 done single cycle", 64'(done_o), 64'd0);
  endtask

  localparam logic [63:0] KA = 64'h0123456789ABCDEF;
  localparam logic [63:0] KB = 64'h23456789ABCDEF01;
  localparam logic [63:0] KC = 64'h456789ABCDEF0123;
  localparam logic [63:0] KS = 64'h133457799BBCDFF1;
  localparam logic [63:0] PT = 64'h5468652071756663;
  localparam logic [63:0] CT = 64'hA826FD8CE53B855F;

  task automatic t_reset;
    check("R9 reset data", data_o, 64'd0);
    check("R9 reset done", 64'(done_o), 64'd0);
  endtask

  task automatic t_kat_enc;
    logic [63:0] r;
    run_op(1'b0, PT, {k56(KA), k56(KB), k56(KC)}, r, "R1");
    check("R1 three-key encrypt", r, CT);
  endtask

  task automatic t_kat_dec;
    logic [63:0] r;
    run_op(1'b1, CT, {k56(KA), k56(KB), k56(KC)}, r, "R2");
    check("R2 three-key decrypt", r, PT);
  endtask

  task automatic t_single;
    logic [63:0] r;
    run_op(1'b0, 64'h0123456789ABCDEF, {3{k56(KS)}}, r, "R3");
    check("R3 equal keys as DES", r, 64'h85E813540F0AB405);
    run_op(1'b0, 64'h8000000000000000, {3{k56(64'h0101010101010101)}}, r, "R3");
    check("R3 equal keys as DES b", r, 64'h95F8A5E5DD31D900);
  endtask

  task automatic t_key_fields;
    logic [63:0] r;
    // K1=K2 cancel: encrypt equals DES under K3
    run_op(1'b0, 64'h0123456789ABCDEF, {k56(KA), k56(KA), k56(KS)}, r, "R3");
    check("R3 K3 field", r, 64'h85E813540F0AB405);
    // K2=K3 cancel: decrypt equals DES decrypt under K1
    run_op(1'b1, 64'h85E813540F0AB405, {k56(KS), k56(KA), k56(KA)}, r, "R3");
    check("R3 K1 field", r, 64'h0123456789ABCDEF);
  endtask

  task automatic t_roundtrip;
    logic [63:0] c, p, d;
    logic [167:0] k;
    for (int i = 0; i < 3; i++) begin
      d = 64'hFEDCBA9876543210 ^ (64'h1111111111111111 * 64'(i + 1));
      k = {k56(KC ^ 64'(i)), k56(KS), k56(KB + 64'(i))};
      run_op(1'b0, d, k, c, "R2");
      run_op(1'b1, c, k, p, "R2");
      check("R2 round trip", p, d);
    end
  endtask

  task automatic t_busy_ignore;
    int n;
    n = 0;
    @(negedge clk_i);
    decrypt_i = 1'b0; data_i = PT; key_i = {k56(KA), k56(KB), k56(KC)}; start_i = 1'b1;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      if (k == 10) begin
        start_i = 1'b1; decrypt_i = 1'b1; data_i = 64'hDEADBEEFCAFEF00D;
      end
      if (done_o) begin n = k; break; end
    end
    start_i = 1'b0;
    check("R5 done timing with mid start", 64'(n), 64'd49);
    check("R5 result with mid start", data_o, CT);
    @(negedge clk_i);
  endtask

  task automatic t_hold;
    logic [63:0] r;
    run_op(1'b0, PT, {k56(KA), k56(KB), k56(KC)}, r, "R6");
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      data_i = 64'(i) * 64'h0F0F0F0F0F0F0F0F;
      decrypt_i = i[0];
    end
    @(negedge clk_i);
    check("R6 output held", data_o, CT);
    check("R6 no extra done", 64'(done_o), 64'd0);
  endtask

  task automatic t_parity;
    @(negedge clk_i);
    parity_en_i = 1'b1;
    key_i = {21{8'h01}};
    #1ns check("R7 all bytes odd", 64'(parity_err_o), 64'd0);
    key_i[8*5 +: 8] = 8'h03;
    #1ns check("R7 even byte 5", 64'(parity_err_o), 64'd1);
    key_i = {21{8'h01}};
    key_i[167:160] = 8'hFE;
    #1ns check("R7 odd top byte", 64'(parity_err_o), 64'd0);
    key_i[167:160] = 8'h00;
    #1ns check("R7 even top byte", 64'(parity_err_o), 64'd1);
    parity_en_i = 1'b0;
    #1ns check("R8 disabled", 64'(parity_err_o), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_kat_enc();
    t_kat_dec();
    t_single();
    t_key_fields();
    t_roundtrip();
    t_busy_ignore();
    t_hold();
    t_parity();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule